// File: doc/BRIEF.md
# 8-bit ALU Flag Generator

This block performs one arithmetic or logic operation per accepted request on two byte operands. One is the accumulator value and the other is the temporary-register value. It keeps a six-bit condition register that the operation may update. The supported operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, increment and decrement. The carry and borrow inputs come from the stored carry bit.

Requests arrive on a valid/ready channel that carries the operation code, both operands and a per-flag update enable. Each accepted request produces one result beat on an output valid/ready channel, in the order the requests were accepted. The condition register is written when a request is accepted, so the flags seen at the output always belong to the result beside them. Increment and decrement work on the temporary operand. Any register's value can be routed there, so their zero, sign, parity, auxiliary and overflow flags apply to registers other than the accumulator too.

Back-pressure rules:
- A request is taken on a rising edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high when the output stage is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output beat and the flags do not change.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset `out_valid` is 0, `out_flags` is all zero, and `in_ready` is 1.
- R2: A request is accepted when `in_valid` and `in_ready` are both high, with `in_ready = !out_valid || out_ready`. The result appears on `out_valid` on the next clock and stays unchanged while `out_ready` is low. Results leave in acceptance order.
- R3: Operation codes are: 0 add, 1 add with carry, 2 subtract (acc − tmp), 3 subtract with borrow (acc − tmp − CY), 4 AND, 5 OR, 6 XOR, 7 increment, 8 decrement. The result is the low 8 bits of that operation.
- R4: Flag bit 4 (sign) equals result bit 7. Flag bit 3 (zero) is 1 exactly when the result is 0.
- R5: Flag bit 1 (parity) is 1 when the result has an even number of ones.
- R6: Flag bit 2 (auxiliary) is set in these cases:
  - Additions and increment: a carry leaves bit 3, counting the carry-in.
  - Subtractions and decrement: a borrow is needed into the low nibble.
- R7: Flag bit 0 (carry) holds the carry out of bit 7 for additions. For subtractions it is set when a borrow occurred. Add with carry and subtract with borrow use the stored carry as their carry-in or borrow-in.
- R8: Flag bit 5 (overflow) is set when the two's-complement result of an add, subtract, increment or decrement is out of range.
- R9: Increment (tmp + 1) and decrement (tmp − 1) never change the carry flag, even when its enable bit is set.
- R10: AND, OR and XOR clear carry, auxiliary and overflow (where enabled). They set sign, zero and parity from the result.
- R11: `in_flag_en[i]` = 0 leaves flag bit i at its previous value. Bit positions are as listed in R4–R8.
- R12: Codes 9–15 return the accumulator operand as the result and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| in_op | input | 4 | Operation code (R3) |
| in_acc | input | W | Accumulator operand |
| in_tmp | input | W | Temporary-register operand |
| in_flag_en | input | 6 | Per-flag update enable |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | W | Operation result |
| out_flags | output | 6 | Condition register after this operation |

## Verification
The bench builds the block with its default width of 8, which is the width the nibble carry and the sign bit are defined for. For every operation it walks all 256 accumulator values against sixteen temporary values. Those temporary values cover each high nibble and a spread of low nibbles, so nibble carries and borrows, signed wrap points and zero results are all reached. Flag enables are varied on a fixed schedule, and carry-in chains build up naturally. A periodic stall on `out_ready` exercises the hold and ordering rules alongside the arithmetic.

// File: rtl/alufg_pkg.sv
package alufg_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } alu_op_e;

  localparam int FLAG_COUNT = 6;
  localparam int FL_CY   = 0;
  localparam int FL_PAR  = 1;
  localparam int FL_AUX  = 2;
  localparam int FL_ZERO = 3;
  localparam int FL_SIGN = 4;
  localparam int FL_OVF  = 5;
  localparam int NIBBLE  = 4;
endpackage

// File: rtl/alufg_adder.sv
module alufg_adder
  import alufg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  input  logic         sub_mode,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         aux,
  output logic         ovf
);
  logic [W:0]      full;
  logic [NIBBLE:0] low;

  assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c_in};
  assign low  = {1'b0, x[NIBBLE-1:0]} + {1'b0, y[NIBBLE-1:0]} + {{NIBBLE{1'b0}}, c_in};
  assign sum  = full[W-1:0];
  // In subtract mode the operand is inverted, so carry-out low means borrow.
  assign cy   = full[W] ^ sub_mode;
  assign aux  = low[NIBBLE] ^ sub_mode;
  assign ovf  = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alufg_flag_eval.sv
module alufg_flag_eval #(
  parameter int W = 8
) (
  input  logic [W-1:0] value,
  output logic         sign,
  output logic         zero,
  output logic         parity
);
  assign sign   = value[W-1];
  assign zero   = ~|value;
  assign parity = ~^value;
endmodule

// File: rtl/alufg_core.sv
module alufg_core
  import alufg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]            op,
  input  logic [W-1:0]          a,
  input  logic [W-1:0]          b,
  input  logic                  cy_in,
  output logic [W-1:0]          result,
  output logic [FLAG_COUNT-1:0] calc,
  output logic [FLAG_COUNT-1:0] allowed
);
  logic [W-1:0] x, y, sum, logic_r;
  logic         cin, sub, is_arith;
  logic         a_cy, a_aux, a_ovf;
  logic         f_sign, f_zero, f_par;

  always_comb begin
    x        = a;
    y        = b;
    cin      = 1'b0;
    sub      = 1'b0;
    is_arith = 1'b1;
    logic_r  = a;
    allowed  = '1;
    case (op)
      OP_ADD: ;
      OP_ADC: cin = cy_in;
      OP_SUB: begin y = ~b; cin = 1'b1; sub = 1'b1; end
      OP_SBB: begin y = ~b; cin = ~cy_in; sub = 1'b1; end
      OP_INC: begin x = b; y = '0; cin = 1'b1; allowed[FL_CY] = 1'b0; end
      OP_DEC: begin x = b; y = ~W'(1); cin = 1'b1; sub = 1'b1; allowed[FL_CY] = 1'b0; end
      OP_AND: begin is_arith = 1'b0; logic_r = a & b; end
      OP_OR:  begin is_arith = 1'b0; logic_r = a | b; end
      OP_XOR: begin is_arith = 1'b0; logic_r = a ^ b; end
      default: begin is_arith = 1'b0; logic_r = a; allowed = '0; end
    endcase
  end

  alufg_adder #(.W(W)) u_adder (
    .x(x), .y(y), .c_in(cin), .sub_mode(sub),
    .sum(sum), .cy(a_cy), .aux(a_aux), .ovf(a_ovf)
  );

  assign result = is_arith ? sum : logic_r;

  alufg_flag_eval #(.W(W)) u_eval (
    .value(result), .sign(f_sign), .zero(f_zero), .parity(f_par)
  );

  assign calc[FL_CY]   = is_arith & a_cy;
  assign calc[FL_AUX]  = is_arith & a_aux;
  assign calc[FL_OVF]  = is_arith & a_ovf;
  assign calc[FL_SIGN] = f_sign;
  assign calc[FL_ZERO] = f_zero;
  assign calc[FL_PAR]  = f_par;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alufg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [3:0]            in_op,
  input  logic [W-1:0]          in_acc,
  input  logic [W-1:0]          in_tmp,
  input  logic [FLAG_COUNT-1:0] in_flag_en,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [W-1:0]          out_result,
  output logic [FLAG_COUNT-1:0] out_flags
);
  logic                  fire, valid_q;
  logic [W-1:0]          res_q, result;
  logic [FLAG_COUNT-1:0] flag_q, flag_nxt, calc, allowed;

  assign in_ready   = !valid_q || out_ready;
  assign fire       = in_valid && in_ready;
  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_flags  = flag_q;

  alufg_core #(.W(W)) u_core (
    .op(in_op), .a(in_acc), .b(in_tmp), .cy_in(flag_q[FL_CY]),
    .result(result), .calc(calc), .allowed(allowed)
  );

  for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_flag
    assign flag_nxt[i] = (in_flag_en[i] && allowed[i]) ? calc[i] : flag_q[i];

    // R11: a disabled flag keeps its value
    p_masked_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fire && !in_flag_en[i] |=> flag_q[i] == $past(flag_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flag_q  <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      res_q   <= result;
      flag_q  <= flag_nxt;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags));

  p_sign_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_flag_en[FL_SIGN] && (in_op <= 4'd8) |=> out_flags[FL_SIGN] == out_result[W-1]);

  p_zero_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_flag_en[FL_ZERO] && (in_op <= 4'd8) |=> out_flags[FL_ZERO] == (out_result == '0));

  p_parity_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_flag_en[FL_PAR] && (in_op <= 4'd8) |=> out_flags[FL_PAR] == ~^out_result);

  p_incdec_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_INC || in_op == OP_DEC) |=> out_flags[FL_CY] == $past(flag_q[FL_CY]));

  p_logic_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR) && in_flag_en[FL_CY]
    |=> !out_flags[FL_CY]);

  p_undef_pass_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (in_op > 4'd8) |=> out_result == $past(in_acc) && out_flags == $past(flag_q));
endmodule

// File: tb/test_alu_flag_unit.sv
`timescale 1ns/1ps
module test_alu_flag_unit;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [W-1:0] in_acc = '0, in_tmp = '0;
  logic [5:0] in_flag_en = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [W-1:0] out_result;
  logic [5:0] out_flags;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [5:0] mflags = '0;
  logic [7:0] eres_q[$];
  logic [5:0] efl_q[$];
  logic [3:0] eop_q[$];
  logic       stalled = 1'b0;
  logic [7:0] hold_res;
  logic [5:0] hold_fl;

  always #2.5 clk = ~clk;

  alu_flag_unit #(.W(W)) i_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_tmp(in_tmp), .in_flag_en(in_flag_en),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  // R2: periodic back-pressure, changed just after the edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    out_ready <= ((cyc % 7) != 3) && ((cyc % 11) != 5);
  end

  function automatic string flag_tag(input int bitn, input logic [3:0] op);
    if (op > 4'd8) return "R12";
    case (bitn)
      0: return (op == 4'd7 || op == 4'd8) ? "R9" : (op >= 4'd4 ? "R10" : "R7 (R11 enable)");
      1: return "R5 (R11 enable)";
      2: return (op >= 4'd4 && op <= 4'd6) ? "R10" : "R6 (R11 enable)";
      3: return "R4 zero (R11 enable)";
      4: return "R4 sign (R11 enable)";
      default: return (op >= 4'd4 && op <= 4'd6) ? "R10" : "R8 (R11 enable)";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input int a, input int b,
                       input logic [5:0] en, output logic [7:0] r);
    int res, cin;
    logic cy, ac, ov;
    logic [5:0] c, allow;
    allow = 6'h3F; cy = 0; ac = 0; ov = 0; res = 0;
    case (op)
      4'd0, 4'd1: begin
        cin = (op == 4'd1) ? int'(mflags[0]) : 0;
        res = a + b + cin;
        cy  = res > 255;
        ac  = ((a & 15) + (b & 15) + cin) > 15;
        res = res & 255;
        ov  = (((a >> 7) & 1) == ((b >> 7) & 1)) && (((res >> 7) & 1) != ((a >> 7) & 1));
      end
      4'd2, 4'd3: begin
        cin = (op == 4'd3) ? int'(mflags[0]) : 0;
        res = a - b - cin;
        cy  = res < 0;
        ac  = ((a & 15) - (b & 15) - cin) < 0;
        res = res & 255;
        ov  = (((a >> 7) & 1) != ((b >> 7) & 1)) && (((res >> 7) & 1) != ((a >> 7) & 1));
      end
      4'd4: res = a & b;
      4'd5: res = a | b;
      4'd6: res = a ^ b;
      4'd7: begin res = (b + 1) & 255; ac = (b & 15) == 15; ov = (b == 127); allow[0] = 0; end
      4'd8: begin res = (b - 1) & 255; ac = (b & 15) == 0;  ov = (b == 128); allow[0] = 0; end
      default: begin res = a; allow = '0; end
    endcase
    r = res[7:0];
    c = {ov, r[7], (r == 8'd0), ac, ~^r, cy};
    for (int i = 0; i < 6; i++)
      if (en[i] && allow[i]) mflags[i] = c[i];
  endtask

  task automatic send(input logic [3:0] op, input int a, input int b, input logic [5:0] en);
    logic [7:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_acc = a[7:0]; in_tmp = b[7:0]; in_flag_en = en;
    model(op, a, b, en, r);
    eres_q.push_back(r); efl_q.push_back(mflags); eop_q.push_back(op);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  // Output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) begin
        checks++;
        if (!out_valid || out_result != hold_res || out_flags != hold_fl) begin
          fails++;
          $display("FAIL R2 stall hold: got v=%0b r=%02h f=%02h exp r=%02h f=%02h",
                   out_valid, out_result, out_flags, hold_res, hold_fl);
        end
      end
      stalled = out_valid && !out_ready;
      hold_res = out_result;
      hold_fl  = out_flags;
      if (out_valid && out_ready) begin
        if (eres_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected beat: got r=%02h exp none", out_result);
        end else begin
          logic [7:0] er; logic [5:0] ef; logic [3:0] eo; logic [5:0] d;
          er = eres_q.pop_front(); ef = efl_q.pop_front(); eo = eop_q.pop_front();
          checks++;
          if (out_result !== er) begin
            fails++;
            $display("FAIL %s result op=%0d: got %02h exp %02h",
                     (eo > 4'd8) ? "R12" : ((eo == 4'd7 || eo == 4'd8) ? "R9" : "R3"),
                     eo, out_result, er);
          end
          checks++;
          d = out_flags ^ ef;
          if (d != 6'd0) begin
            int fb;
            fb = 0;
            for (int i = 5; i >= 0; i--) if (d[i]) fb = i;
            fails++;
            $display("FAIL %s flags op=%0d bit %0d: got %02h exp %02h",
                     flag_tag(fb, eo), eo, fb, out_flags, ef);
          end
        end
      end
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no completion exp completion");
    finish_run();
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_flags !== 6'd0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b f=%02h rdy=%0b exp v=0 f=00 rdy=1",
               out_valid, out_flags, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_flags !== 6'd0) begin
      fails++;
      $display("FAIL R1 after release: got v=%0b f=%02h exp v=0 f=00", out_valid, out_flags);
    end

    // R3..R11: sweep every op, all acc values, sixteen tmp values
    for (int op = 0; op < 9; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          int b;
          logic [5:0] en;
          b  = (bi << 4) | ((a + bi * 3) & 15);
          en = ((n % 5) == 0) ? 6'((n * 37) & 63) : 6'h3F;
          n++;
          send(4'(op), a, b, en);
        end
      end
    end

    // R12: undefined codes
    for (int op = 9; op < 16; op++)
      for (int k = 0; k < 8; k++)
        send(4'(op), (k * 53 + op) & 255, (k * 29) & 255, 6'h3F);

    @(negedge clk);
    in_valid = 1'b0;
    while (eres_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule